// File: doc/BRIEF.md
# Watchdog Timer with Sticky Reset Lock

This block watches for a stalled system. It counts ticks of a separate oscillator clock enable. When the count reaches the timeout picked by a 4-bit prescale code, it issues a one-cycle reset request. Software keeps the watchdog from expiring by pulsing the kick input. Changing the prescale code or switching the watchdog on also restarts the count.

An expiry sets a sticky flag, and the flag holds the effective enable at one. A failing system therefore keeps receiving reset requests until software clears the flag, and only after that can software turn the enable off. To guard against stray writes, the enable bit and the prescale code only accept a write within a short window after a write that sets the change-enable bit. The prescale code is split across non-adjacent bits of the control word. Codes above the valid range fall back to the longest valid timeout.

Top module: `wdt_sticky`

## Requirements
- R1: While `rst_n` is low, and after it rises, `rst_req` and `en_eff` are 0. The flag is clear, the prescale code is 0 and the change window is closed.
- R2: The fields of the control write word are as follows.
  - Bit 5 is the most significant bit of the prescale code, and bits 2..0 are its lower three bits.
  - Bit 3 is the enable.
  - Bit 4 is the change-enable.
  - Writing 1 to bit 7 clears the flag.
  - Bit 6 is unused.
- R3: A write of bit 4 = 1 opens a window for the writes on the next 4 clock edges. The enable bit and the prescale code take a write only inside that window. Outside it, they keep their values.
- R4: Codes 0 to 9 select a timeout of 2^(BASE_LOG2 + code) oscillator ticks. BASE_LOG2 defaults to 11, which gives 2K to 1024K ticks.
- R5: Codes 10 to 15 give the same timeout as code 9.
- R6: The counter advances only on clock edges where `osc_tick` is high. While the effective enable is 0, the counter is held at zero and no request is issued.
- R7: Each of the following sets the counter to zero on the edge it is applied, and the next request comes T ticks after that edge:
  - a `kick` pulse;
  - an accepted write that changes the prescale code;
  - the switch-on of the enable.
- R8: `rst_req` is high for exactly one cycle, following the edge on which the T-th tick lands. The count then starts again from zero.
- R9: An expiry sets the flag. Only a write with bit 7 = 1 clears it; the reset request does not. While the flag is set, requests repeat every T ticks.
- R10: While the flag is set, `en_eff` reads 1. A write that clears the enable during that time leaves the enable set, and it stays set after the flag is later cleared.
- R11: Once the flag is clear, an accepted write with bit 3 = 0 brings `en_eff` to 0 and stops the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable marking an oscillator tick |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| kick | input | 1 | Restart the timeout count |
| rst_req | output | 1 | One-cycle system reset request |
| en_eff | output | 1 | Effective watchdog enable (enable bit or flag) |

## Verification
A write, kick or code change is applied on the edge that samples it, and `en_eff` is checked on the next falling edge. A reset request is due T tick-edges after the last restart edge. It appears on the falling edge that follows that edge, because one register lies between the expiry compare and the output. For every restart, the driver records the edge number at which the request is due, counting ticks on the gated-tick pattern. The monitor counts edges and, on each falling edge, matches every `rst_req` pulse against the head of that queue. A pulse that arrives early or unannounced, or that never arrives, is reported against its requirement.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CODE_W    = 4;
  localparam int MAX_CODE  = 9;
  localparam int BIT_PS_HI = 5;
  localparam int BIT_CE    = 4;
  localparam int BIT_EN    = 3;
  localparam int BIT_FLAG  = 7;

  // gather the split prescale field out of a control word
  function automatic logic [CODE_W-1:0] pick_code(input logic [7:0] d);
    return {d[BIT_PS_HI], d[2:0]};
  endfunction

  // reserved codes fall back to the longest valid timeout
  function automatic logic [CODE_W-1:0] map_code(input logic [CODE_W-1:0] c);
    return (int'(c) > MAX_CODE) ? CODE_W'(MAX_CODE) : c;
  endfunction
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs #(
  parameter int WIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       expire,
  output logic       en_bit,
  output logic       flag,
  output logic [wdt_pkg::CODE_W-1:0] code,
  output logic       code_chg,
  output logic       win_open
);
  import wdt_pkg::*;
  localparam int WIN_W = $clog2(WIN + 1);

  logic [WIN_W-1:0]  win_cnt;
  logic [CODE_W-1:0] code_next;
  logic              wr_ok;

  assign win_open  = (win_cnt != '0);
  assign wr_ok     = reg_wr && win_open;
  assign code_next = pick_code(reg_wdata);
  assign code_chg  = wr_ok && (code_next != code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_cnt <= '0;
    else if (reg_wr && reg_wdata[BIT_CE]) win_cnt <= WIN_W'(WIN);
    else if (win_open) win_cnt <= win_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_bit <= 1'b0;
      code   <= '0;
    end else if (wr_ok) begin
      en_bit <= reg_wdata[BIT_EN] | flag;
      code   <= code_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (expire) flag <= 1'b1;
    else if (reg_wr && reg_wdata[BIT_FLAG]) flag <= 1'b0;
  end

  // R3
  ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !win_open) |=> ($stable(code) && $stable(en_bit)));
  // R9
  expire_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !expire && !(reg_wr && reg_wdata[BIT_FLAG])) |=> flag);
  // R10
  en_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> en_bit);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int BASE_LOG2 = 11,
  parameter int MAX_CODE  = wdt_pkg::MAX_CODE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic run,
  input  logic restart,
  input  logic [wdt_pkg::CODE_W-1:0] code_eff,
  output logic expire,
  output logic rst_req
);
  localparam int CNT_W = BASE_LOG2 + MAX_CODE + 1;

  // terminal value of the count for a given (already mapped) code
  function automatic logic [CNT_W-1:0] last_of(input logic [wdt_pkg::CODE_W-1:0] c);
    logic [CNT_W-1:0] one;
    one = CNT_W'(1);
    return (one << (BASE_LOG2 + int'(c))) - one;
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             at_last;

  assign last    = last_of(code_eff);
  assign at_last = (cnt == last);
  assign expire  = run && !restart && osc_tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run || restart) cnt <= '0;
    else if (osc_tick) cnt <= at_last ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else rst_req <= expire;
  end

  // R8
  rst_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !rst_req);
endmodule

// File: rtl/wdt_sticky.sv
module wdt_sticky #(
  parameter int BASE_LOG2 = 11,
  parameter int WIN       = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       kick,
  output logic       rst_req,
  output logic       en_eff
);
  import wdt_pkg::*;

  logic              en_bit;
  logic              flag;
  logic [CODE_W-1:0] code_raw;
  logic [CODE_W-1:0] code_eff;
  logic              code_chg;
  logic              win_open;
  logic              expire;
  logic              restart;

  assign code_eff = map_code(code_raw);
  assign en_eff   = en_bit | flag;
  assign restart  = kick | code_chg;

  wdt_ctrl_regs #(.WIN(WIN)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .expire   (expire),
    .en_bit   (en_bit),
    .flag     (flag),
    .code     (code_raw),
    .code_chg (code_chg),
    .win_open (win_open)
  );

  wdt_counter #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_tick(osc_tick),
    .run     (en_eff),
    .restart (restart),
    .code_eff(code_eff),
    .expire  (expire),
    .rst_req (rst_req)
  );

  // R5
  code_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(code_eff) <= MAX_CODE) && ((code_raw == code_eff) || (int'(code_raw) > MAX_CODE)));
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rst_req && !en_eff));
endmodule

// File: tb/test_wdt_sticky.sv
module test_wdt_sticky;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       kick = 1'b0;
  logic       rst_req;
  logic       en_eff;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit gate = 1'b0;
  bit done = 1'b0;

  typedef struct { int at; string tag; } exp_t;
  exp_t q[$];

  wdt_sticky #(.BASE_LOG2(3), .WIN(4)) i_wdt_sticky (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .kick(kick), .rst_req(rst_req), .en_eff(en_eff)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  // gated ticks land on odd-numbered edges
  always @(negedge clk) osc_tick <= gate ? (cyc % 2 == 0) : 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pops the expected request times
  always @(negedge clk) begin
    if (!done) begin
      if (q.size() > 0 && q[0].at < cyc) begin
        check(1'b0, q[0].tag, cyc, q[0].at);
        void'(q.pop_front());
      end
      if (rst_req) begin
        if (q.size() == 0) check(1'b0, "R8 unexpected request", cyc, -1);
        else begin
          check(q[0].at == cyc, q[0].tag, cyc, q[0].at);
          void'(q.pop_front());
        end
      end
    end
  end

  task automatic push(input int at, input string tag);
    exp_t e;
    e.at = at; e.tag = tag;
    q.push_back(e);
  endtask

  // caller sits at a falling edge; returns the edge that applies the write
  task automatic drive(input logic [7:0] d, output int e);
    reg_wr = 1'b1; reg_wdata = d; e = cyc + 1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic do_kick(output int e);
    kick = 1'b1; e = cyc + 1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic wait_until(input int v);
    while (cyc < v) @(negedge clk);
  endtask

  task automatic disarm(input string tag);
    int e;
    drive(8'h90, e);
    drive(8'h00, e);
    check(en_eff == 1'b0, tag, en_eff, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog timeout", cyc, 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e, c, k, k2;
    repeat (3) @(negedge clk);
    check(rst_req == 1'b0 && en_eff == 1'b0, "R1 reset outputs", {rst_req, en_eff}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rst_req == 1'b0 && en_eff == 1'b0, "R1 after reset", {rst_req, en_eff}, 0);

    // R3: enable write with no open window
    drive(8'h08, e);
    check(en_eff == 1'b0, "R3 closed window", en_eff, 0);
    repeat (20) @(negedge clk);
    // R3: write five edges after the change-enable is too late
    drive(8'h10, c);
    wait_until(c + 4);
    drive(8'h08, e);
    check(e == c + 5 && en_eff == 1'b0, "R3 window expired", en_eff, 0);
    // R3: write on the fourth edge is accepted
    drive(8'h10, c);
    wait_until(c + 3);
    drive(8'h08, e);
    check(e == c + 4 && en_eff == 1'b1, "R3 window last edge", en_eff, 1);

    // R4/R8/R9: code 0 gives T=8, repeated while the flag is set
    push(e + 8, "R4 code0 timeout");
    push(e + 16, "R9 repeated request");
    push(e + 24, "R9 third request");
    wait_until(e + 16);
    drive(8'h10, c);
    drive(8'h00, c);
    check(en_eff == 1'b1, "R10 disable blocked by flag", en_eff, 1);
    drive(8'h80, c);
    check(en_eff == 1'b1, "R10 enable kept after flag clear", en_eff, 1);
    wait_until(e + 24);
    disarm("R11 disable after flag clear");
    repeat (40) @(negedge clk);
    check(q.size() == 0, "R11 no further requests", q.size(), 0);

    // R7: kick restarts the count (code 1, T=16)
    drive(8'h10, c);
    drive(8'h09, e);
    wait_until(e + 9);
    do_kick(k);
    wait_until(k + 11);
    do_kick(k2);
    push(k2 + 16, "R7 kick restart");
    wait_until(k2 + 16);
    disarm("R11 disarm after kick test");

    // R7: an accepted code change restarts with the new timeout (code 2, T=32)
    drive(8'h10, c);
    drive(8'h08, e);
    wait_until(e + 4);
    drive(8'h10, c);
    drive(8'h0A, k);
    push(k + 32, "R7 code change restart");
    wait_until(k + 32);
    disarm("R11 disarm after code change");

    // R2: bit 5 is the top prescale bit, code 8 -> T=2048
    drive(8'h10, c);
    drive(8'h28, e);
    push(e + 2048, "R2 split field code8");
    wait_until(e + 2048);
    disarm("R11 disarm after code8");

    // R5: reserved code 15 behaves as code 9 -> T=4096
    drive(8'h10, c);
    drive(8'h2F, e);
    push(e + 4096, "R5 reserved code maps to 9");
    wait_until(e + 4096);
    disarm("R11 disarm after reserved code");

    // R6: ticks only on odd edges, code 0 needs 8 ticks
    gate = 1'b1;
    drive(8'h10, c);
    drive(8'h08, e);
    push(e + ((e % 2 == 1) ? 16 : 15), "R6 gated ticks");
    wait_until(e + 16);
    disarm("R11 disarm after gated ticks");
    gate = 1'b0;

    repeat (30) @(negedge clk);
    check(q.size() == 0, "R8 all requests seen", q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule